// File: doc/BRIEF.md
# Multi-Channel Sensor Sampling Sequencer

The sequencer takes one sampling command whose payload is a channel bitmask. It walks the set bits from the lowest index upward. For each selected channel it raises a request on that channel's sensor port and waits for the acknowledge, or for a fixed timeout. It then turns the readings into one framed response packet, with one beat per selected channel. Each beat carries a 4-bit channel index and a signed 32-bit fixed-point reading with 8 fractional bits. The first beat is marked start-of-packet and the last beat end-of-packet. The reserved word 0x8000_0000 means the reading is not valid.

The command input uses a valid/ready handshake. The sequencer holds `cmd_ready` low while a packet is being produced, so only one command is in flight at a time. The response stream is output-valid only and has no back-pressure: every beat is presented for exactly one cycle and the consumer must take it. Each sensor port is a plain request/acknowledge pair. The request is held high until the acknowledge arrives or the timeout expires, and the reading is sampled in the acknowledge cycle. A parameter mask declares which channels exist.

Everything runs on one clock, specified for operation between 10 MHz and 100 MHz. Reset is active high, and its deassertion is synchronous to the clock.

Top module: `sensor_seq`

## Requirements
- R1: Out of reset `cmd_ready` is high, `rsp_valid` is low and no sensor request is raised. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_data` is sampled in that cycle.
- R2: A non-zero mask produces exactly one beat per set bit, in ascending channel order (bit 0 first). `rsp_chan` carries the bit index as an unsigned 4-bit number.
- R3: The first beat of a packet has `rsp_sop`=1 and the last has `rsp_eop`=1. A one-beat packet has both set. The markers are never high without `rsp_valid`.
- R4: After a non-zero mask is taken, `cmd_ready` is low until the cycle in which the end-of-packet beat is on the output. It is high again in that same cycle.
- R5: For an implemented channel that acknowledges in time, `rsp_data` equals the 32-bit sensor word presented on that channel during its acknowledge cycle. The word is signed, with 8 fractional bits.
- R6: An all-zero mask is accepted and yields one beat with channel 0, data 0x8000_0000, and `rsp_sop` and `rsp_eop` both high, in the cycle after acceptance.
- R7: A set bit for a channel that `IMPL_MASK` marks absent yields a beat for that channel with data 0x8000_0000, and no request is ever raised on that channel.
- R8: The request stays high for at most `TIMEOUT` cycles. An acknowledge in any of those cycles, the last one included, returns the sensor word. With no acknowledge by then, the beat carries 0x8000_0000 and sequencing moves on to the next selected channel.
- R9: At most one sensor request is high at any time. A request falls in the cycle after it is acknowledged, and no request is high while `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Active-high reset, deasserted synchronously |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_data | input | N | Channel selection mask, bit i selects channel i |
| sns_req | output | N | Per-channel sample request |
| sns_ack | input | N | Per-channel acknowledge, reading valid in this cycle |
| sns_data | input | N*DW | Per-channel reading, channel i in bits [i*DW +: DW] |
| rsp_valid | output | 1 | Response beat present (one cycle, no back-pressure) |
| rsp_sop | output | 1 | First beat of packet |
| rsp_eop | output | 1 | Last beat of packet |
| rsp_chan | output | 4 | Channel the beat belongs to |
| rsp_data | output | DW | Signed fixed-point reading, or 0x8000_0000 when invalid |

## Verification
Two events can land on the same cycle here. The first is a sensor acknowledge arriving in the last cycle of the timeout window. The stub delay is set to exactly `TIMEOUT-1` and then to `TIMEOUT`, and the bench expects the real reading in the first case and the invalid code in the second. The second is the end-of-packet beat coinciding with `cmd_ready` rising. It is judged by watching `cmd_ready` on every cycle of every packet across a full sweep of all 512 masks, run under two delay maps, one of which forces timeouts on several channels.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  localparam int CHW = 4;
  localparam logic [31:0] READING_BAD = 32'h8000_0000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEL,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic            sop;
    logic            eop;
    logic [CHW-1:0]  chan;
    logic [31:0]     data;
  } beat_t;
endpackage

// File: rtl/sseq_pick.sv
// Lowest-set-bit selector: index of the next channel and the mask left after it.
module sseq_pick #(
  parameter int N  = 9,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  rest
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

  // Clearing the lowest set bit: x & (x - 1)
  assign rest = mask & (mask - N'(1));
endmodule

// File: rtl/sseq_port.sv
// Drives one request at a time and resolves it by acknowledge or timeout.
module sseq_port #(
  parameter int N       = 9,
  parameter int DW      = 32,
  parameter int TIMEOUT = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] chan,
  input  logic [N-1:0]  sns_ack,
  input  logic [N*DW-1:0] sns_data,
  output logic [N-1:0]  sns_req,
  output logic          done,
  output logic [DW-1:0] done_data
);
  import sseq_pkg::*;

  logic          active_q;
  logic [IW-1:0] chan_q;
  logic [TW-1:0] cnt_q;
  logic          hit;
  logic          expired;

  assign hit     = active_q && sns_ack[chan_q];
  assign expired = active_q && !hit && (cnt_q == TW'(TIMEOUT - 1));
  assign done    = hit || expired;
  assign done_data = hit ? sns_data[chan_q*DW +: DW] : DW'(READING_BAD);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      sns_req[i] = active_q && (chan_q == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      chan_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      chan_q   <= chan;
      cnt_q    <= '0;
    end else if (done) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/sseq_frame.sv
// Output register stage for response beats; markers only live with valid.
module sseq_frame #(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  sseq_pkg::beat_t beat,
  output logic           rsp_valid,
  output logic           rsp_sop,
  output logic           rsp_eop,
  output logic [3:0]     rsp_chan,
  output logic [DW-1:0]  rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_sop   <= 1'b0;
      rsp_eop   <= 1'b0;
      rsp_chan  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire;
      rsp_sop   <= fire && beat.sop;
      rsp_eop   <= fire && beat.eop;
      if (fire) begin
        rsp_chan <= beat.chan;
        rsp_data <= DW'(beat.data);
      end
    end
  end
endmodule

// File: rtl/sensor_seq.sv
module sensor_seq #(
  parameter int N       = 9,
  parameter int DW      = 32,
  parameter int TIMEOUT = 64,
  parameter logic [N-1:0] IMPL_MASK = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [N-1:0]    cmd_data,
  output logic [N-1:0]    sns_req,
  input  logic [N-1:0]    sns_ack,
  input  logic [N*DW-1:0] sns_data,
  output logic            rsp_valid,
  output logic            rsp_sop,
  output logic            rsp_eop,
  output logic [3:0]      rsp_chan,
  output logic [DW-1:0]   rsp_data
);
  import sseq_pkg::*;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  seq_state_e    state_q;
  logic [N-1:0]  pend_q;
  logic          first_q;
  logic [IW-1:0] idx;
  logic [N-1:0]  rest;
  logic          accept;
  logic          empty_cmd;
  logic          impl_hit;
  logic          start;
  logic          fire;
  logic          port_done;
  logic [DW-1:0] port_data;
  beat_t         beat;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign empty_cmd = (cmd_data == '0);
  assign impl_hit  = IMPL_MASK[idx];

  sseq_pick #(.N(N)) u_pick (
    .mask (pend_q),
    .idx  (idx),
    .rest (rest)
  );

  sseq_port #(.N(N), .DW(DW), .TIMEOUT(TIMEOUT)) u_port (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .chan      (idx),
    .sns_ack   (sns_ack),
    .sns_data  (sns_data),
    .sns_req   (sns_req),
    .done      (port_done),
    .done_data (port_data)
  );

  always_comb begin
    fire      = 1'b0;
    start     = 1'b0;
    beat.sop  = first_q;
    beat.eop  = (rest == '0);
    beat.chan = CHW'(idx);
    beat.data = READING_BAD;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && empty_cmd) begin
          fire      = 1'b1;
          beat.sop  = 1'b1;
          beat.eop  = 1'b1;
          beat.chan = '0;
        end
      end
      ST_SEL: begin
        if (impl_hit) start = 1'b1;
        else          fire  = 1'b1;
      end
      ST_WAIT: begin
        if (port_done) begin
          fire      = 1'b1;
          beat.data = 32'(port_data);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept && !empty_cmd) begin
            pend_q  <= cmd_data;
            first_q <= 1'b1;
            state_q <= ST_SEL;
          end
        end
        ST_SEL, ST_WAIT: begin
          if (start) begin
            state_q <= ST_WAIT;
          end else if (fire) begin
            pend_q  <= rest;
            first_q <= 1'b0;
            state_q <= (rest == '0) ? ST_IDLE : ST_SEL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sseq_frame #(.DW(DW)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .beat      (beat),
    .rsp_valid (rsp_valid),
    .rsp_sop   (rsp_sop),
    .rsp_eop   (rsp_eop),
    .rsp_chan  (rsp_chan),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/sensor_seq_chk.sv
module sensor_seq_chk #(
  parameter int N  = 9,
  parameter int DW = 32,
  parameter logic [N-1:0] IMPL_MASK = '1
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [N-1:0]  cmd_data,
  input logic [N-1:0]  sns_req,
  input logic [N-1:0]  sns_ack,
  input logic          rsp_valid,
  input logic          rsp_sop,
  input logic          rsp_eop,
  input logic [3:0]    rsp_chan,
  input logic [DW-1:0] rsp_data
);
  localparam logic [DW-1:0] BAD = DW'(32'h8000_0000);

  p_one_req_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sns_req));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (sns_req == '0));

  p_ack_drops_r9: assert property (@(posedge clk) disable iff (rst)
    ((sns_req & sns_ack) != '0) |=> (sns_req == '0));

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_eop) |-> !cmd_ready);

  p_take_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_data != '0)) |=> !cmd_ready);

  p_marker_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_sop || rsp_eop) |-> rsp_valid);

  p_empty_beat_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_data == '0)) |=>
      (rsp_valid && rsp_sop && rsp_eop && rsp_chan == 4'd0 && rsp_data == BAD));

  p_absent_bad_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (32'(rsp_chan) < N) && (((IMPL_MASK >> rsp_chan) & N'(1)) == '0))
      |-> (rsp_data == BAD));
endmodule

bind sensor_seq sensor_seq_chk #(.N(N), .DW(DW), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_data  (cmd_data),
  .sns_req   (sns_req),
  .sns_ack   (sns_ack),
  .rsp_valid (rsp_valid),
  .rsp_sop   (rsp_sop),
  .rsp_eop   (rsp_eop),
  .rsp_chan  (rsp_chan),
  .rsp_data  (rsp_data)
);

// File: tb/sim_sensor_seq.sv
module sim_sensor_seq;
  import sseq_pkg::*;

  localparam int N  = 9;
  localparam int DW = 32;
  localparam int TO = 8;
  localparam logic [N-1:0] IMPL = 9'h0FF;  // channel 8 absent
  localparam logic [31:0] BADW = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [N-1:0]    cmd_data = '0;
  logic [N-1:0]    sns_req;
  logic [N-1:0]    sns_ack;
  logic [N*DW-1:0] sns_data;
  logic            rsp_valid, rsp_sop, rsp_eop;
  logic [3:0]      rsp_chan;
  logic [DW-1:0]   rsp_data;

  int dly [N];
  int seed = 1;
  int total = 0;
  int bad = 0;
  int ready_viol = 0;
  int req_viol = 0;
  int absent_req = 0;
  logic [N-1:0] prev_hit = '0;

  function automatic logic [31:0] val(int c, int s);
    return 32'(((c * 1000) - 3500 + s) * 256 + c);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_stub
    int sc;
    always @(posedge clk) begin
      if (rst || !sns_req[g]) sc <= 0;
      else sc <= sc + 1;
    end
    assign sns_ack[g] = sns_req[g] && (sc == dly[g]);
    assign sns_data[g*DW +: DW] = val(g, seed);
  end

  sensor_seq #(.N(N), .DW(DW), .TIMEOUT(TO), .IMPL_MASK(IMPL)) u0 (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .sns_req(sns_req), .sns_ack(sns_ack), .sns_data(sns_data),
    .rsp_valid(rsp_valid), .rsp_sop(rsp_sop), .rsp_eop(rsp_eop),
    .rsp_chan(rsp_chan), .rsp_data(rsp_data)
  );

  // Sensor-side observers (R9, R7)
  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(sns_req) > 1) req_viol++;
      if ((sns_req & prev_hit) != '0) req_viol++;
      if (cmd_ready && sns_req != '0) req_viol++;
      if (sns_req[8]) absent_req++;
      prev_hit <= sns_req & sns_ack;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [N-1:0] m);
    beat_t got[$];
    beat_t exp[$];
    bit fin;
    int guard;
    int nsel;
    int k;
    got.delete();
    exp.delete();
    // Expected packet from the requirements
    if (m == '0) begin
      exp.push_back('{sop: 1'b1, eop: 1'b1, chan: 4'd0, data: BADW});  // R6
    end else begin
      nsel = $countones(m);
      k = 0;
      for (int c = 0; c < N; c++) begin
        if (m[c]) begin
          beat_t b;
          b.sop  = (k == 0);
          b.eop  = (k == nsel - 1);
          b.chan = 4'(c);
          b.data = (!IMPL[c] || dly[c] >= TO) ? BADW : val(c, seed);
          exp.push_back(b);
          k++;
        end
      end
    end
    // Drive and collect
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = m;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    fin = 1'b0;
    guard = 0;
    while (!fin && guard < 2000) begin
      if (rsp_valid) begin
        got.push_back('{sop: rsp_sop, eop: rsp_eop, chan: rsp_chan, data: rsp_data});
        if (rsp_eop) fin = 1'b1;
      end
      if (cmd_ready && !(rsp_valid && rsp_eop)) ready_viol++;  // R4
      if (!fin) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(got.size() == exp.size(), "R2 beat count", 32'(got.size()), 32'(exp.size()));
    if (got.size() == exp.size()) begin
      foreach (exp[i]) begin
        chk(got[i].chan == exp[i].chan, "R2 channel order", 32'(got[i].chan), 32'(exp[i].chan));
        chk(got[i].sop == exp[i].sop && got[i].eop == exp[i].eop, "R3 markers",
            {30'd0, got[i].sop, got[i].eop}, {30'd0, exp[i].sop, exp[i].eop});
        chk(got[i].data == exp[i].data, "R5/R7/R8 reading", got[i].data, exp[i].data);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) dly[i] = i % 4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 no beat after reset", 32'(rsp_valid), 32'd0);
    chk(sns_req == '0, "R1 no request after reset", 32'(sns_req), 32'd0);

    // Sweep 1: every mask, all implemented channels answer in time
    seed = 1;
    for (int m = 0; m < (1 << N); m++) run_cmd(N'(m));

    // Sweep 2: delay map that times out on several channels (R8)
    seed = 7;
    for (int i = 0; i < N; i++) dly[i] = (i * 3) % 11;
    for (int m = 0; m < (1 << N); m++) run_cmd(N'(m));

    // Ack on the last timeout cycle versus one cycle late (R8)
    seed = 3;
    for (int i = 0; i < N; i++) dly[i] = 1;
    dly[1] = TO - 1;
    run_cmd(9'b0_0000_0111);
    dly[1] = TO;
    run_cmd(9'b0_0000_0111);
    dly[1] = 1000;
    run_cmd(9'b1_0000_0010);
    // Single channel and empty commands back to back (R3, R6)
    dly[1] = 2;
    run_cmd(9'b0_0000_0010);
    run_cmd(9'b0_0000_0000);
    run_cmd(9'b1_0000_0000);

    repeat (4) @(negedge clk);
    chk(ready_viol == 0, "R4 ready held low during packet", 32'(ready_viol), 32'd0);
    chk(req_viol == 0, "R9 request discipline", 32'(req_viol), 32'd0);
    chk(absent_req == 0, "R7 no request on absent channel", 32'(absent_req), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule